// File: doc/BRIEF.md
# UART Receive Holding Queue with Per-Character Error Flags

This block is the buffer on the receive side of a UART. The serial front end reports each completed character as a one-cycle pulse, together with its data bits and the value sampled for its first stop bit. The block stores these characters in a small first-in first-out queue, with two entries by default. Each entry carries its own framing-error flag and its own overrun flag. The host sees the oldest character and its flags on the read port, and a read strobe pops that character.

If a character completes while the queue is full, it waits in a one-character holding stage that models the occupied shift register. It moves into the queue in the same cycle that a host read frees an entry. If the front end reports a new start bit while the queue is full and the holding stage is occupied, the waiting character is discarded. The overrun is then marked on the character the host will read next. Clearing the receiver enable empties the queue and the holding stage at once.

A control write port holds a receive interrupt enable. The interrupt request is high while unread data is present and the enable is set.

Top module: `uart_rx_holdq`

## Requirements
- R1: After reset the queue is empty and `st_avail`, `st_ferr`, `st_ovr` and `irq_rx` are all 0.
- R2: A character reported by `shf_done` while the queue has room is visible on `rd_data` one cycle later if the queue was empty. Characters leave in arrival order. Each `rd_pop` pulse removes the head entry at the next clock edge.
- R3: The queue holds up to DEPTH characters. `st_avail` is 1 exactly while it holds at least one character. A `rd_pop` pulse on an empty queue has no effect.
- R4: `st_ferr` is 1 when the head character's stop bit was sampled as 0 and 0 when it was sampled as 1. The flag belongs to that character: it stays until that character is popped, and the next character then shows its own value.
- R5: A character completed while the queue is full is held back. It enters the queue in the same cycle that a `rd_pop` frees an entry, so no character is lost and the order is kept.
- R6: When the queue is full, a character is waiting in the holding stage and `start_det` pulses, the waiting character is discarded. `st_ovr` becomes 1 on the next cycle for the current head character and stays 1 until that character is popped.
- R7: A `start_det` pulse does not set `st_ovr` when the queue is not full, or when the queue is full but no character is waiting.
- R8: While `rx_en` is 0 the queue and the holding stage are emptied at the next clock edge. Completed characters are ignored. `st_avail` reads 0.
- R9: A `csr_wr` pulse loads `csr_wdata[0]` as the receive interrupt enable, which resets to 0. `irq_rx` equals `st_avail` AND that enable.
- R10: Bits 3 to 1 of `csr_wdata` correspond to the read-only status flags (overrun, framing error, receive-complete). Writing them has no effect on `st_avail`, `st_ferr` or `st_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; 0 flushes and blocks storage |
| shf_done | input | 1 | One-cycle pulse: the shift register finished a character |
| shf_data | input | DATA_W | Data bits of the finished character |
| shf_stop | input | 1 | Sampled value of the first stop bit |
| start_det | input | 1 | One-cycle pulse: a new start bit was detected |
| rd_pop | input | 1 | Host read strobe; pops the head character |
| rd_data | output | DATA_W | Head character |
| st_avail | output | 1 | Receive complete: unread data present |
| st_ferr | output | 1 | Framing error of the head character |
| st_ovr | output | 1 | Overrun marked on the head character |
| csr_wr | input | 1 | Control write strobe |
| csr_wdata | input | 4 | Control write data; bit 0 is the interrupt enable |
| irq_rx | output | 1 | Receive-complete interrupt request |

## Verification
The bench sweeps every occupancy from empty up to one beyond the queue depth. Each level is filled and then drained while the bench checks order. This separates direct storage from storage through the holding stage, and shows whether any character is lost at the full boundary. All four framing-error patterns over two queued characters are tried, which shows whether the flag travels with its own entry. Start-bit pulses are applied in three situations: with a character waiting, with a full queue and nothing waiting, and with a partly filled queue. Only the first of these may flag an overrun. Flush, interrupt-enable writes and writes to the read-only bit positions are each checked against the status outputs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // control word layout shared by the control register and its users
   localparam int CSR_W          = 4;
   localparam int CSR_IRQ_EN_BIT = 0;

   // where the character pushed into the queue this cycle comes from
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_HOLD = 2'd1,
      SRC_LIVE = 2'd2
   } push_src_e;

endpackage

// File: rtl/rxq_hold.sv
module rxq_hold
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              shf_done,
   input  logic [DATA_W-1:0] shf_data,
   input  logic              shf_stop,
   input  logic              start_det,
   input  logic              space,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_ferr,
   output logic              ovr_evt
);

   logic              hold_vld;
   logic [DATA_W-1:0] hold_data;
   logic              hold_ferr;
   logic              live;
   push_src_e         src;

   assign live = rx_en & shf_done;

   always_comb begin
      src = SRC_NONE;
      if (rx_en && space) begin
         if (hold_vld)  src = SRC_HOLD;
         else if (live) src = SRC_LIVE;
      end
   end

   assign push      = (src != SRC_NONE);
   assign push_data = (src == SRC_HOLD) ? hold_data : shf_data;
   assign push_ferr = (src == SRC_HOLD) ? hold_ferr : ~shf_stop;

   // a waiting character is lost when the line starts another one
   assign ovr_evt = rx_en & hold_vld & ~space & (start_det | live);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_data <= '0;
         hold_ferr <= 1'b0;
      end else if (!rx_en) begin
         hold_vld  <= 1'b0;
      end else if (hold_vld && space) begin
         hold_vld <= live;
         if (live) begin
            hold_data <= shf_data;
            hold_ferr <= ~shf_stop;
         end
      end else if (hold_vld) begin
         if (live) begin
            hold_data <= shf_data;
            hold_ferr <= ~shf_stop;
         end else if (start_det) begin
            hold_vld <= 1'b0;
         end
      end else if (live && !space) begin
         hold_vld  <= 1'b1;
         hold_data <= shf_data;
         hold_ferr <= ~shf_stop;
      end
   end

   // R6
   ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_evt && !live) |=> !hold_vld);

   // R5
   hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && hold_vld && !space && !start_det && !live)
      |=> (hold_vld && $stable(hold_data)));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_ferr,
   input  logic              pop,
   input  logic              ovr_mark,
   output logic              space,
   output logic              not_empty,
   output logic [DATA_W-1:0] head_data,
   output logic              head_ferr,
   output logic              head_ovr
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  cnt;
   logic              pop_ok, push_ok;
   logic [DATA_W-1:0] slot_data [DEPTH];
   logic              slot_ferr [DEPTH];
   logic              slot_ovr  [DEPTH];

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   assign not_empty = (cnt != '0);
   assign pop_ok    = pop & not_empty & ~flush;
   assign push_ok   = push & ~flush;
   assign space     = (cnt != FULL) | pop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
         if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_data[i] <= '0;
            slot_ferr[i] <= 1'b0;
            slot_ovr[i]  <= 1'b0;
         end else if (flush) begin
            slot_ferr[i] <= 1'b0;
            slot_ovr[i]  <= 1'b0;
         end else if (push_ok && wr_ptr == PTR_W'(i)) begin
            slot_data[i] <= push_data;
            slot_ferr[i] <= push_ferr;
            slot_ovr[i]  <= 1'b0;
         end else if (ovr_mark && not_empty && rd_ptr == PTR_W'(i)) begin
            slot_ovr[i]  <= 1'b1;
         end
      end
   end

   always_comb begin
      head_data = '0;
      head_ferr = 1'b0;
      head_ovr  = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (rd_ptr == PTR_W'(k)) begin
            head_data = slot_data[k];
            head_ferr = slot_ferr[k] & not_empty;
            head_ovr  = slot_ovr[k]  & not_empty;
         end
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);

   // R2
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !push_ok) |=> (cnt == $past(cnt) - 1'b1));

   // R4
   ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (not_empty && !pop && !flush) |=> $stable(head_ferr));

endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl
   import rxq_pkg::*;
#(
   parameter bit IRQ_EN_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_wr,
   input  logic [CSR_W-1:0] csr_wdata,
   input  logic             avail,
   output logic             irq
);

   logic irq_en_q;
   logic unused_ro_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_en_q <= IRQ_EN_RST;
      else if (csr_wr) irq_en_q <= csr_wdata[CSR_IRQ_EN_BIT];
   end

   // status positions in the control word are read-only: writes drop them
   assign unused_ro_bits = ^csr_wdata[CSR_W-1:1];

   assign irq = avail & irq_en_q;

   // R9
   irq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && !csr_wdata[CSR_IRQ_EN_BIT]) |=> !irq);

endmodule

// File: rtl/uart_rx_holdq.sv
module uart_rx_holdq
   import rxq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 2,
   parameter bit IRQ_EN_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              shf_done,
   input  logic [DATA_W-1:0] shf_data,
   input  logic              shf_stop,
   input  logic              start_det,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              st_avail,
   output logic              st_ferr,
   output logic              st_ovr,
   input  logic              csr_wr,
   input  logic [3:0]        csr_wdata,
   output logic              irq_rx
);

   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_rx_holdq: DATA_W must be 5 to 9");
   end
   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("uart_rx_holdq: DEPTH must be 2 to 64");
   end
   if (CSR_W != 4) begin : g_bad_csr
      $error("uart_rx_holdq: control word must be 4 bits");
   end

   logic              space, push, push_ferr, ovr_evt;
   logic [DATA_W-1:0] push_data;
   logic              head_ferr, head_ovr;

   rxq_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .shf_done  (shf_done),
      .shf_data  (shf_data),
      .shf_stop  (shf_stop),
      .start_det (start_det),
      .space     (space),
      .push      (push),
      .push_data (push_data),
      .push_ferr (push_ferr),
      .ovr_evt   (ovr_evt)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (~rx_en),
      .push      (push),
      .push_data (push_data),
      .push_ferr (push_ferr),
      .pop       (rd_pop),
      .ovr_mark  (ovr_evt),
      .space     (space),
      .not_empty (st_avail),
      .head_data (rd_data),
      .head_ferr (head_ferr),
      .head_ovr  (head_ovr)
   );

   assign st_ferr = head_ferr;
   assign st_ovr  = head_ovr;

   rxq_ctl #(.IRQ_EN_RST(IRQ_EN_RST)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_wr    (csr_wr),
      .csr_wdata (csr_wdata),
      .avail     (st_avail),
      .irq       (irq_rx)
   );

   // R8
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !st_avail);

   // R6
   ovr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovr && !rd_pop && rx_en) |=> st_ovr);

   // R10
   ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && st_avail && !rd_pop && !shf_done && !start_det && rx_en)
      |=> (st_avail && $stable(st_ferr) && $stable(st_ovr)));

endmodule

// File: tb/uart_rx_holdq_tb.sv
`timescale 1ns/1ps
module uart_rx_holdq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1;
   logic       shf_done = 1'b0;
   logic [7:0] shf_data = '0;
   logic       shf_stop = 1'b1;
   logic       start_det = 1'b0;
   logic       rd_pop = 1'b0;
   logic [7:0] rd_data;
   logic       st_avail, st_ferr, st_ovr;
   logic       csr_wr = 1'b0;
   logic [3:0] csr_wdata = '0;
   logic       irq_rx;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   uart_rx_holdq u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .shf_done(shf_done),
      .shf_data(shf_data), .shf_stop(shf_stop), .start_det(start_det),
      .rd_pop(rd_pop), .rd_data(rd_data), .st_avail(st_avail),
      .st_ferr(st_ferr), .st_ovr(st_ovr), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .irq_rx(irq_rx)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d, input logic stop);
      shf_done = 1'b1; shf_data = d; shf_stop = stop;
      tick();
      shf_done = 1'b0; shf_stop = 1'b1;
   endtask

   task automatic pop();
      rd_pop = 1'b1;
      tick();
      rd_pop = 1'b0;
   endtask

   task automatic start_pulse();
      start_det = 1'b1;
      tick();
      start_det = 1'b0;
   endtask

   task automatic csr(input logic [3:0] w);
      csr_wr = 1'b1; csr_wdata = w;
      tick();
      csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic flush();
      rx_en = 1'b0;
      tick();
      rx_en = 1'b1;
      tick();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 avail", st_avail, 0);
      chk("R1 ferr", st_ferr, 0);
      chk("R1 ovr", st_ovr, 0);
      chk("R1 irq", irq_rx, 0);

      // R3 pop on empty queue does nothing
      pop();
      chk("R3 empty pop avail", st_avail, 0);
      send(8'h3C, 1'b1);
      chk("R3 after empty pop data", rd_data, 8'h3C);
      pop();
      chk("R3 drained", st_avail, 0);

      // R2 R5 occupancy sweep 0..DEPTH+1, order kept
      for (int n = 0; n <= 3; n++) begin
         for (int i = 0; i < n; i++) send(8'(8'h40 + n * 4 + i), 1'b1);
         chk("R3 avail after fill", st_avail, (n > 0));
         for (int i = 0; i < n; i++) begin
            chk("R2 R5 order", rd_data, 8'(8'h40 + n * 4 + i));
            chk("R3 avail while data", st_avail, 1);
            pop();
         end
         chk("R3 empty after drain", st_avail, 0);
      end

      // R4 all framing patterns over two entries
      for (int p = 0; p < 4; p++) begin
         send(8'(8'h80 + p), !p[0]);
         send(8'(8'h90 + p), !p[1]);
         chk("R4 ferr head0", st_ferr, p[0]);
         chk("R2 data head0", rd_data, 8'(8'h80 + p));
         tick();
         chk("R4 ferr held", st_ferr, p[0]);
         pop();
         chk("R4 ferr head1", st_ferr, p[1]);
         chk("R2 data head1", rd_data, 8'(8'h90 + p));
         pop();
         chk("R4 ferr empty", st_ferr, 0);
      end

      // R5 held character with error keeps its flag
      send(8'hC0, 1'b1); send(8'hC1, 1'b1); send(8'hC2, 1'b0);
      chk("R5 head while held", rd_data, 8'hC0);
      pop();
      chk("R5 still two", rd_data, 8'hC1);
      pop();
      chk("R5 held entered", rd_data, 8'hC2);
      chk("R5 held ferr", st_ferr, 1);
      pop();
      chk("R5 empty", st_avail, 0);

      // R6 overrun
      send(8'hD0, 1'b1); send(8'hD1, 1'b1); send(8'hD2, 1'b1);
      chk("R6 no ovr before start", st_ovr, 0);
      start_pulse();
      chk("R6 ovr set", st_ovr, 1);
      chk("R6 ovr head", rd_data, 8'hD0);
      csr(4'b0000);
      chk("R10 ovr survives write", st_ovr, 1);
      tick();
      chk("R6 ovr kept", st_ovr, 1);
      pop();
      chk("R6 next head", rd_data, 8'hD1);
      chk("R6 ovr cleared", st_ovr, 0);
      pop();
      chk("R6 waiting char dropped", st_avail, 0);

      // R7 start bits that are not overruns
      send(8'hE0, 1'b1);
      start_pulse();
      chk("R7 partial no ovr", st_ovr, 0);
      send(8'hE1, 1'b1);
      start_pulse();
      chk("R7 full no wait no ovr", st_ovr, 0);
      chk("R7 data intact", rd_data, 8'hE0);
      pop(); pop();
      chk("R7 empty", st_avail, 0);

      // R8 flush
      send(8'hF0, 1'b1); send(8'hF1, 1'b0); send(8'hF2, 1'b1);
      rx_en = 1'b0;
      tick();
      chk("R8 flushed", st_avail, 0);
      chk("R8 ferr cleared", st_ferr, 0);
      send(8'hF3, 1'b1);
      chk("R8 ignored while off", st_avail, 0);
      rx_en = 1'b1;
      tick();
      chk("R8 held char gone", st_avail, 0);
      send(8'hF4, 1'b1);
      chk("R8 new char after enable", rd_data, 8'hF4);
      pop();

      // R9 interrupt gating
      csr(4'b0001);
      chk("R9 irq empty", irq_rx, 0);
      send(8'h11, 1'b1);
      chk("R9 irq data", irq_rx, 1);
      pop();
      chk("R9 irq after pop", irq_rx, 0);
      csr(4'b0000);
      send(8'h12, 1'b1);
      chk("R9 irq disabled", irq_rx, 0);
      chk("R9 avail still", st_avail, 1);
      pop();

      // R10 writes to read-only bit positions
      send(8'h21, 1'b0);
      csr(4'b0000);
      chk("R10 ferr kept", st_ferr, 1);
      chk("R10 avail kept", st_avail, 1);
      pop();
      csr(4'b1110);
      chk("R10 avail not set", st_avail, 0);
      chk("R10 ferr not set", st_ferr, 0);
      chk("R10 ovr not set", st_ovr, 0);
      chk("R10 irq en from bit0 only", irq_rx, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule